// File: doc/BRIEF.md
# Embedded Sync Code Video Decoder

This block takes a multiplexed 4:2:2 component video stream, one word per rising edge of the video clock (nominally 27 MHz). The stream carries no separate sync wires. The block hunts the stream for timing reference codes. Each code is a three-word preamble followed by a status word.

The status word carries a field flag (F), a vertical-blanking flag (V) and a horizontal flag (H). H=1 marks the end of active video and H=0 marks the start of active video. The word also holds four protection bits. The block checks those bits, and it can optionally repair a status word with a single-bit fault. From each accepted code it drives horizontal sync, vertical sync and field outputs.

The incoming words also pass through a short, fixed delay to `vid_data`. Alongside them, `vid_active` marks the picture samples that lie between a start-of-active-video code outside vertical blanking and the next code. A receiver needs no line-standard setting, because every output follows the codes alone.

Top module: `vsd_decoder`

## Requirements
- R1: `rst` is synchronous and active high. At the first clock edge that samples it high, `hsync`, `vsync`, `field`, `vid_active`, `code_err`, `code_fix` and `vid_data` all become 0. Any partly received preamble is also forgotten.
- R2: A code is recognised when three consecutive words are all-ones, all-zeros and all-zeros, followed by a status word. Its status byte is `vid_in[DATA_W-1 -: 8]`, read MSB first as 1, F, V, H, P3, P2, P1, P0. Preambles that overlap one another are recognised correctly.
- R3: A status byte is valid when bit 7 is 1 and P3 = V^H, P2 = F^H, P1 = F^V and P0 = F^V^H.
- R4: `hsync` equals H of the most recently accepted code. It changes one clock edge after the edge that samples the status word.
- R5: `vsync` equals V and `field` equals F of the most recently accepted code, with the same timing as R4.
- R6: A recognised code that is not accepted raises `code_err` for exactly one cycle, with the timing of R4. In that case `hsync`, `vsync` and `field` keep their previous values.
- R7: With `CORRECT_EN`=1, a status byte one bit away from a valid byte (all eight bits counted) is accepted as that valid byte, and `code_fix` pulses for one cycle with the timing of R4. With `CORRECT_EN`=0 such a byte is an error, and `code_fix` stays 0.
- R8: `vid_active` is high for an output word only when two conditions hold. First, the most recent code accepted before that word had H=0 and V=0. Second, the word is not one of the four words of any recognised code, whether that code was accepted or not.
- R9: A word sampled at clock edge n appears on `vid_data` right after edge n+4, with its `vid_active` alongside.
- R10: Between accepted codes, `hsync`, `vsync` and `field` do not change, whatever the data words contain.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Video clock, rising edge active |
| rst | input | 1 | Synchronous reset, active high |
| vid_in | input | DATA_W | Multiplexed component video words |
| hsync | output | 1 | H flag of the last accepted code |
| vsync | output | 1 | V flag of the last accepted code |
| field | output | 1 | F flag of the last accepted code |
| vid_active | output | 1 | Qualifies `vid_data` as a picture sample |
| vid_data | output | DATA_W | Input words delayed to match `vid_active` |
| code_err | output | 1 | One-cycle pulse for a rejected code |
| code_fix | output | 1 | One-cycle pulse for a repaired code |

## Verification
A fault in the preamble history shows up one cycle after the status word. It appears either as a missing or spurious change of `hsync`, `vsync` or `field`, or as a wrong `code_err` pulse. A fault in the code-word marking or the active state shows on `vid_active` four or five cycles later, when the affected word leaves the delay line. Two instances, one with repair enabled and one without, are compared on every clock against a behavioural model. The stimulus covers clean lines, every single-bit and several double-bit status faults, overlapping preambles, noise rich in all-ones and all-zero words, and a reset in the middle of a preamble. Any divergence therefore surfaces within one to five cycles of its cause.

// File: rtl/vsd_pkg.sv
`timescale 1ns/1ps
package vsd_pkg;

  // status field width and preamble length of a timing code
  localparam int STAT_W  = 8;
  localparam int PRE_LEN = 3;
  localparam int N_CAND  = 8;

  typedef struct packed {
    logic f;
    logic v;
    logic h;
  } vsd_flags_t;

  // protected status byte for a given flag triple
  function automatic logic [STAT_W-1:0] vsd_codeword(input logic [2:0] fvh);
    logic f;
    logic v;
    logic h;
    f = fvh[2];
    v = fvh[1];
    h = fvh[0];
    return {1'b1, f, v, h, v ^ h, f ^ h, f ^ v, f ^ v ^ h};
  endfunction

endpackage

// File: rtl/vsd_trs_search.sv
`timescale 1ns/1ps
module vsd_trs_search
  import vsd_pkg::*;
#(
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [DATA_W-1:0] din,
  output logic              hit,
  output logic              stat_vld,
  output logic [STAT_W-1:0] stat_q
);

  localparam logic [DATA_W-1:0] ALL_ONES  = '1;
  localparam logic [DATA_W-1:0] ALL_ZEROS = '0;

  // hist[i] holds the word sampled i+1 edges ago
  logic [DATA_W-1:0] hist [PRE_LEN];
  logic [PRE_LEN-1:0] pos_ok;

  for (genvar i = 0; i < PRE_LEN; i++) begin : g_cmp
    if (i == PRE_LEN - 1) begin : g_lead
      assign pos_ok[i] = (hist[i] == ALL_ONES);
    end else begin : g_zero
      assign pos_ok[i] = (hist[i] == ALL_ZEROS);
    end
  end

  assign hit = &pos_ok;

  always_ff @(posedge clk) begin
    if (rst) begin
      for (int i = 0; i < PRE_LEN; i++) hist[i] <= '0;
      stat_vld <= 1'b0;
      stat_q   <= '0;
    end else begin
      hist[0] <= din;
      for (int i = 1; i < PRE_LEN; i++) hist[i] <= hist[i-1];
      stat_vld <= hit;
      if (hit) stat_q <= din[DATA_W-1 -: STAT_W];
    end
  end

  // two status words can never sit on consecutive edges
  AST_STAT_SPACED: assert property (@(posedge clk) disable iff (rst) stat_vld |=> !stat_vld); // R2

endmodule

// File: rtl/vsd_trs_check.sv
`timescale 1ns/1ps
module vsd_trs_check
  import vsd_pkg::*;
#(
  parameter bit CORRECT_EN = 1'b1
) (
  input  logic [STAT_W-1:0] stat,
  output vsd_flags_t        flags,
  output logic              clean,
  output logic              fixed
);

  logic [N_CAND-1:0] exact;
  logic [N_CAND-1:0] near;
  logic [2:0]        sel;

  // compare the received byte against every legal code word
  for (genvar c = 0; c < N_CAND; c++) begin : g_cand
    localparam logic [STAT_W-1:0] CW = vsd_codeword(3'(c));
    logic [STAT_W-1:0] diff;
    assign diff     = stat ^ CW;
    assign exact[c] = (diff == '0);
    assign near[c]  = ($countones(diff) == 1);
  end

  always_comb begin
    clean = |exact;
    fixed = CORRECT_EN && !clean && (|near);
    sel   = '0;
    for (int c = 0; c < N_CAND; c++) begin
      if (exact[c] || (fixed && near[c])) sel = 3'(c);
    end
    flags = vsd_flags_t'(sel);
  end

endmodule

// File: rtl/vsd_sync_state.sv
`timescale 1ns/1ps
module vsd_sync_state
  import vsd_pkg::*;
(
  input  logic       clk,
  input  logic       rst,
  input  logic       stat_vld,
  input  vsd_flags_t flags,
  input  logic       clean,
  input  logic       fixed,
  output logic       hsync,
  output logic       vsync,
  output logic       field,
  output logic       act_state,
  output logic       code_err,
  output logic       code_fix
);

  logic accept;
  assign accept = stat_vld && (clean || fixed);

  always_ff @(posedge clk) begin
    if (rst) begin
      hsync     <= 1'b0;
      vsync     <= 1'b0;
      field     <= 1'b0;
      act_state <= 1'b0;
      code_err  <= 1'b0;
      code_fix  <= 1'b0;
    end else begin
      code_err <= stat_vld && !accept;
      code_fix <= stat_vld && fixed;
      if (accept) begin
        field     <= flags.f;
        vsync     <= flags.v;
        hsync     <= flags.h;
        act_state <= !flags.h && !flags.v;
      end
    end
  end

  AST_ERR_HOLDS: assert property (@(posedge clk) disable iff (rst) code_err |-> $stable({field, vsync, hsync, act_state})); // R6
  AST_ERR_PULSE: assert property (@(posedge clk) disable iff (rst) code_err |=> !code_err); // R6
  AST_QUIET_NO_CODE: assert property (@(posedge clk) disable iff (rst) !stat_vld |=> $stable({field, vsync, hsync})); // R10

endmodule

// File: rtl/vsd_data_align.sv
`timescale 1ns/1ps
module vsd_data_align
  import vsd_pkg::*;
#(
  parameter int DATA_W = 8,
  parameter int DEPTH  = PRE_LEN + 1
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [DATA_W-1:0] din,
  input  logic              hit,
  input  logic              act_state,
  output logic [DATA_W-1:0] vid_data,
  output logic              vid_active
);

  logic [DATA_W-1:0] pipe [DEPTH];
  logic [DEPTH-1:0]  tag;

  // a hit marks the status word and the preamble words still in flight
  always_ff @(posedge clk) begin
    if (rst) begin
      for (int k = 0; k < DEPTH; k++) pipe[k] <= '0;
      tag        <= '0;
      vid_data   <= '0;
      vid_active <= 1'b0;
    end else begin
      pipe[0] <= din;
      tag[0]  <= hit;
      for (int k = 1; k < DEPTH; k++) begin
        pipe[k] <= pipe[k-1];
        tag[k]  <= tag[k-1] | hit;
      end
      vid_data   <= pipe[DEPTH-1];
      vid_active <= act_state && !tag[DEPTH-1];
    end
  end

  AST_CODE_NOT_ACTIVE: assert property (@(posedge clk) disable iff (rst) vid_active |-> (!$past(hit, 2) && !$past(hit, 3) && !$past(hit, 4) && !$past(hit, 5))); // R8

endmodule

// File: rtl/vsd_decoder.sv
`timescale 1ns/1ps
module vsd_decoder
  import vsd_pkg::*;
#(
  parameter int DATA_W     = 8,
  parameter bit CORRECT_EN = 1'b1
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [DATA_W-1:0] vid_in,
  output logic              hsync,
  output logic              vsync,
  output logic              field,
  output logic              vid_active,
  output logic [DATA_W-1:0] vid_data,
  output logic              code_err,
  output logic              code_fix
);

  logic              hit;
  logic              stat_vld;
  logic [STAT_W-1:0] stat_q;
  vsd_flags_t        flags;
  logic              clean;
  logic              fixed;
  logic              act_state;

  vsd_trs_search #(.DATA_W(DATA_W)) u_search (
    .clk      (clk),
    .rst      (rst),
    .din      (vid_in),
    .hit      (hit),
    .stat_vld (stat_vld),
    .stat_q   (stat_q)
  );

  vsd_trs_check #(.CORRECT_EN(CORRECT_EN)) u_check (
    .stat  (stat_q),
    .flags (flags),
    .clean (clean),
    .fixed (fixed)
  );

  vsd_sync_state u_state (
    .clk       (clk),
    .rst       (rst),
    .stat_vld  (stat_vld),
    .flags     (flags),
    .clean     (clean),
    .fixed     (fixed),
    .hsync     (hsync),
    .vsync     (vsync),
    .field     (field),
    .act_state (act_state),
    .code_err  (code_err),
    .code_fix  (code_fix)
  );

  vsd_data_align #(.DATA_W(DATA_W), .DEPTH(PRE_LEN + 1)) u_align (
    .clk        (clk),
    .rst        (rst),
    .din        (vid_in),
    .hit        (hit),
    .act_state  (act_state),
    .vid_data   (vid_data),
    .vid_active (vid_active)
  );

  AST_PREAMBLE_SEEN: assert property (@(posedge clk) disable iff (rst) stat_vld |-> ($past(vid_in, 2) == '0 && $past(vid_in, 3) == '0 && $past(vid_in, 4) == '1)); // R2
  AST_STAT_CAPTURE: assert property (@(posedge clk) disable iff (rst) stat_vld |-> (stat_q == $past(vid_in[DATA_W-1 -: STAT_W], 1))); // R2
  AST_ERR_FIX_EXCL: assert property (@(posedge clk) disable iff (rst) !(code_err && code_fix)); // R7

endmodule

// File: tb/vsd_decoder_bench.sv
`timescale 1ns/1ps
module vsd_decoder_bench;

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic [7:0] din = '0;
  bit         done = 1'b0;
  int         n_cmp = 0;
  int         n_bad = 0;

  always #10 clk = ~clk;

  logic       a_hs, a_vs, a_fd, a_act, a_err, a_fix;
  logic [7:0] a_data;
  logic       b_hs, b_vs, b_fd, b_act, b_err, b_fix;
  logic [7:0] b_data;

  vsd_decoder #(.DATA_W(8), .CORRECT_EN(1'b1)) u_vsd_decoder (
    .clk(clk), .rst(rst), .vid_in(din),
    .hsync(a_hs), .vsync(a_vs), .field(a_fd), .vid_active(a_act),
    .vid_data(a_data), .code_err(a_err), .code_fix(a_fix)
  );

  vsd_decoder #(.DATA_W(8), .CORRECT_EN(1'b0)) u_vsd_decoder_nofix (
    .clk(clk), .rst(rst), .vid_in(din),
    .hsync(b_hs), .vsync(b_vs), .field(b_fd), .vid_active(b_act),
    .vid_data(b_data), .code_err(b_err), .code_fix(b_fix)
  );

  // behavioural reference: index 1 = repair enabled, index 0 = disabled
  logic [7:0] hq[$];
  bit         tq[$];
  bit         ab0[$];
  bit         ab1[$];
  bit         mf[2], mv[2], mh[2], mact[2], merr[2], mfix[2];
  bit         pend;
  logic [7:0] pst;
  bit         last_rst;
  logic [7:0] e_data;
  bit         e_act0, e_act1;

  // status byte built from the R3 formulas
  function automatic logic [7:0] word_of(input bit f, input bit v, input bit h);
    return {1'b1, f, v, h, v ^ h, f ^ h, f ^ v, f ^ v ^ h};
  endfunction

  task automatic decode(input int k);
    bit found = 0;
    bit fx = 0;
    int sel = 0;
    for (int c = 0; c < 8; c++) begin
      int d;
      d = $countones(word_of(c[2], c[1], c[0]) ^ pst);
      if (d == 0 || (d == 1 && k == 1)) begin
        found = 1;
        sel = c;
        fx = (d == 1);
      end
    end
    if (found) begin
      mf[k] = sel[2];
      mv[k] = sel[1];
      mh[k] = sel[0];
      mact[k] = !sel[0] && !sel[1];
      mfix[k] = fx;
    end else begin
      merr[k] = 1;
    end
  endtask

  task automatic model_edge();
    int sz;
    last_rst = rst;
    if (rst) begin
      hq.delete(); tq.delete(); ab0.delete(); ab1.delete();
      for (int k = 0; k < 2; k++) begin
        mf[k] = 0; mv[k] = 0; mh[k] = 0; mact[k] = 0; merr[k] = 0; mfix[k] = 0;
      end
      pend = 0;
      e_data = '0; e_act0 = 0; e_act1 = 0;
    end else begin
      for (int k = 0; k < 2; k++) begin
        merr[k] = 0;
        mfix[k] = 0;
        if (pend) decode(k);
      end
      ab0.push_back(mact[0]);
      ab1.push_back(mact[1]);
      hq.push_back(din);
      tq.push_back(1'b0);
      sz = hq.size();
      pend = 0;
      if (sz >= 4 && hq[sz-4] == 8'hFF && hq[sz-3] == 8'h00 && hq[sz-2] == 8'h00) begin
        pend = 1;
        pst = din;
        for (int j = sz - 4; j < sz; j++) tq[j] = 1'b1;
      end
      if (sz >= 5) begin
        e_data = hq[sz-5];
        e_act0 = ab0[sz-5] && !tq[sz-5];
        e_act1 = ab1[sz-5] && !tq[sz-5];
      end else begin
        e_data = '0; e_act0 = 0; e_act1 = 0;
      end
    end
  endtask

  task automatic chk(input string rq, input string nm, input int act, input int exp);
    n_cmp++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s %s: actual=%0d expected=%0d at %0t", rq, nm, act, exp, $time);
    end
  endtask

  function automatic string lab(input string rq);
    return last_rst ? "R1" : rq;
  endfunction

  task automatic compare_all();
    chk(lab("R4 R2"), "hsync", int'(a_hs), int'(mh[1]));
    chk(lab("R5 R3"), "vsync", int'(a_vs), int'(mv[1]));
    chk(lab("R5 R10"), "field", int'(a_fd), int'(mf[1]));
    chk(lab("R6 R3"), "code_err", int'(a_err), int'(merr[1]));
    chk(lab("R7"), "code_fix", int'(a_fix), int'(mfix[1]));
    chk(lab("R8"), "vid_active", int'(a_act), int'(e_act1));
    chk(lab("R9"), "vid_data", int'(a_data), int'(e_data));
    chk(lab("R4 R2"), "nofix hsync", int'(b_hs), int'(mh[0]));
    chk(lab("R5 R3"), "nofix vsync", int'(b_vs), int'(mv[0]));
    chk(lab("R5 R10"), "nofix field", int'(b_fd), int'(mf[0]));
    chk(lab("R7 R6"), "nofix code_err", int'(b_err), int'(merr[0]));
    chk(lab("R7"), "nofix code_fix", int'(b_fix), int'(mfix[0]));
    chk(lab("R8"), "nofix vid_active", int'(b_act), int'(e_act0));
    chk(lab("R9"), "nofix vid_data", int'(b_data), int'(e_data));
  endtask

  task automatic cyc(input logic [7:0] b, input bit r = 1'b0);
    @(negedge clk);
    model_edge();
    compare_all();
    din = b;
    rst = r;
  endtask

  task automatic send_code(input bit f, input bit v, input bit h, input logic [7:0] flip);
    cyc(8'hFF); cyc(8'h00); cyc(8'h00); cyc(word_of(f, v, h) ^ flip);
  endtask

  task automatic send_data(input int n);
    repeat (n) cyc(8'($urandom_range(1, 254)));
  endtask

  task automatic send_line(input bit f, input bit v, input int nact,
                           input logic [7:0] fe, input logic [7:0] fs);
    send_code(f, v, 1'b1, fe);
    send_data(6);
    send_code(f, v, 1'b0, fs);
    send_data(nact);
  endtask

  initial begin
    repeat (3) cyc(8'h00, 1'b1);                       // R1 reset state
    for (int i = 0; i < 4; i++) send_line(1'b0, 1'b1, 20, 8'h00, 8'h00);
    for (int i = 0; i < 6; i++) send_line(1'b0, 1'b0, 40, 8'h00, 8'h00);
    for (int i = 0; i < 4; i++) send_line(1'b1, 1'b0, 30, 8'h00, 8'h00);
    // R7 single-bit faults in every position
    for (int b = 0; b < 8; b++)
      send_line(b[0], 1'b0, 12, 8'(1 << b), 8'(1 << ((b + 3) % 8)));
    // R6 double-bit faults
    for (int b = 0; b < 7; b++) send_line(b[1], 1'b0, 10, 8'(3 << b), 8'(5 << (b % 6)));
    send_line(1'b0, 1'b0, 8, 8'h00, 8'h00);
    // R2 overlapping preambles
    cyc(8'hFF); cyc(8'h00); cyc(8'h00); cyc(8'hFF); cyc(8'h00); cyc(8'h00);
    cyc(word_of(1'b0, 1'b0, 1'b1));
    send_data(5);
    cyc(8'hFF); cyc(8'hFF); cyc(8'h00); cyc(8'h00); cyc(word_of(1'b0, 1'b0, 1'b0));
    send_data(9);
    // back-to-back codes
    send_code(1'b1, 1'b1, 1'b1, 8'h00);
    send_code(1'b1, 1'b0, 1'b0, 8'h00);
    send_data(6);
    // R10 noise rich in reserved words
    repeat (600) begin
      int p;
      p = $urandom_range(0, 5);
      case (p)
        0, 1:    cyc(8'hFF);
        2, 3:    cyc(8'h00);
        4:       cyc(word_of(1'($urandom_range(0, 1)), 1'($urandom_range(0, 1)), 1'($urandom_range(0, 1))));
        default: cyc(8'($urandom_range(0, 255)));
      endcase
    end
    send_line(1'b0, 1'b0, 15, 8'h00, 8'h00);
    // R1 reset inside a preamble, then the tail must not count as a code
    cyc(8'hFF); cyc(8'h00); cyc(8'h00, 1'b1); cyc(8'h00);
    cyc(word_of(1'b1, 1'b1, 1'b1));
    send_data(8);
    send_line(1'b1, 1'b0, 20, 8'h00, 8'h00);
    cyc(8'h20, 1'b1);                                  // R1 reset during active video
    cyc(8'h30);
    send_line(1'b0, 1'b0, 20, 8'h00, 8'h00);
    send_data(8);
    done = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    #2_000_000;
    if (!done) begin
      n_bad++;
      $display("FAIL R1 watchdog: actual=timeout expected=completion");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end

endmodule